// File: doc/BRIEF.md
# Attribute Controller Shared Index/Data Port

This block is the register front end of a display attribute controller. Index bytes and data bytes arrive through a single write port. An internal phase flip-flop decides how each write is taken. In the index phase the byte selects a register and the flip-flop moves to the data phase. In the data phase the byte is stored into the selected register and the flip-flop returns to the index phase. A strobe from a read of the input status port forces the flip-flop back to the index phase, so software can always resynchronise before it writes an index.

The block holds 16 palette entries and five control registers: mode, overscan colour, colour plane enable, pixel panning and colour page. All of them drive output ports. Bit 5 of the last index byte is the video enable, and the display stays blanked while that bit is clear. Two read strobes return either the index view or the currently indexed register through a registered read bus.

Top module: `attr_port_regs`

## Requirements
- R1: After reset the phase flip-flop is in the index phase, video_en_o is 0, the stored index is 0, every palette and control output is 0, and rd_data_o is 0.
- R2: A write in the index phase loads wr_data_i[4:0] as the index and wr_data_i[5] as the video enable. Bits 7:6 are dropped. The flip-flop then moves to the data phase.
- R3: A write in the data phase stores wr_data_i into the indexed register and does not change the index or the video enable. The flip-flop then returns to the index phase.
- R4: A status_rd_i strobe returns the flip-flop to the index phase at the next edge. When a write comes in the same cycle, the write is first handled by the phase in force, and the flip-flop is then left in the index phase.
- R5: The index map is as follows. Indices 0x00 to 0x0F are palette entries of PAL_W bits, where the low PAL_W data bits are kept. 0x10 is the mode register (8 bits). 0x11 is the overscan colour (8 bits). 0x12 is the plane enable (low 4 bits). 0x13 is the pixel panning (low 4 bits). 0x14 is the colour page (low 4 bits). A data write to 0x15 to 0x1F changes no output, and a data read there returns 0.
- R6: video_en_o equals bit 5 of the last index byte. A plane enable value of 0x0F drives all four plane_en_o bits high.
- R7: An rd_idx_i strobe loads rd_data_o with {2'b00, video enable, index[4:0]} at the next edge. It leaves the flip-flop unchanged. rd_idx_i has priority over rd_dat_i.
- R8: An rd_dat_i strobe loads rd_data_o with the indexed register, zero-extended to 8 bits, at the next edge. It leaves the phase flip-flop unchanged.
- R9: A register written at an edge shows its new value on its output port directly after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the shared index/data port |
| wr_data_i | input | 8 | Write byte |
| status_rd_i | input | 1 | Input status read strobe; resets the phase flip-flop |
| rd_idx_i | input | 1 | Read strobe, index view |
| rd_dat_i | input | 1 | Read strobe, indexed register |
| rd_data_o | output | 8 | Registered read data |
| video_en_o | output | 1 | Video enable (index bit 5) |
| pal_o | output | 16*PAL_W | Palette entries, entry n at bits n*PAL_W upward |
| mode_o | output | 8 | Mode register |
| overscan_o | output | 8 | Overscan colour |
| plane_en_o | output | 4 | Colour plane enable |
| pan_o | output | 4 | Pixel panning |
| page_o | output | 4 | Colour page |

## Verification
The register outputs and the video enable change at the same edge that takes the write. The bench drives every strobe at a falling edge and reads the outputs at the next falling edge, which comes after exactly one rising edge. Read data appears one edge after its strobe. The scoreboard monitor wakes on the rising edge where a read strobe is high and compares 1 ns later, against the value the driver queued when it issued that read. The phase flip-flop is never observed directly. Its state is inferred from how the following write is decoded, seen through the index read view and the register outputs.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned NUM_PAL = 16;
  localparam int unsigned DW      = 8;
  localparam int unsigned NIB_W   = 4;

  localparam logic [IDX_W-1:0] IX_MODE  = 5'h10;
  localparam logic [IDX_W-1:0] IX_OVSC  = 5'h11;
  localparam logic [IDX_W-1:0] IX_PLANE = 5'h12;
  localparam logic [IDX_W-1:0] IX_PAN   = 5'h13;
  localparam logic [IDX_W-1:0] IX_PAGE  = 5'h14;

  typedef struct packed {
    logic [DW-1:0]    mode;
    logic [DW-1:0]    ovsc;
    logic [NIB_W-1:0] plane;
    logic [NIB_W-1:0] pan;
    logic [NIB_W-1:0] page;
  } ctrl_regs_t;
endpackage

// File: rtl/attr_phase.sv
module attr_phase
  import attr_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             status_rd_i,
  output logic             data_phase_o,
  output logic             reg_we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             video_en_o
);
  logic             phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             ven_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      idx_q   <= '0;
      ven_q   <= 1'b0;
    end else begin
      if (wr_en_i && !phase_q) begin
        idx_q <= wr_data_i[IDX_W-1:0];
        ven_q <= wr_data_i[5];
      end
      // status read wins over the toggle
      if (status_rd_i)  phase_q <= 1'b0;
      else if (wr_en_i) phase_q <= ~phase_q;
    end
  end

  assign data_phase_o = phase_q;
  assign reg_we_o     = wr_en_i && phase_q;
  assign idx_o        = idx_q;
  assign video_en_o   = ven_q;
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
  import attr_port_pkg::*;
#(
  parameter int unsigned PAL_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NUM_PAL*PAL_W-1:0] pal_o,
  output ctrl_regs_t               ctrl_o
);
  for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
    logic [PAL_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q <= '0;
      else if (we_i && idx_i == IDX_W'(g))      ent_q <= wdata_i[PAL_W-1:0];
    end
    assign pal_o[g*PAL_W +: PAL_W] = ent_q;
  end

  ctrl_regs_t ctrl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      unique case (idx_i)
        IX_MODE:  ctrl_q.mode  <= wdata_i;
        IX_OVSC:  ctrl_q.ovsc  <= wdata_i;
        IX_PLANE: ctrl_q.plane <= wdata_i[NIB_W-1:0];
        IX_PAN:   ctrl_q.pan   <= wdata_i[NIB_W-1:0];
        IX_PAGE:  ctrl_q.page  <= wdata_i[NIB_W-1:0];
        default:  ;
      endcase
    end
  end
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/attr_rdmux.sv
module attr_rdmux
  import attr_port_pkg::*;
#(
  parameter int unsigned PAL_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_idx_i,
  input  logic                     rd_dat_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic                     video_en_i,
  input  logic [NUM_PAL*PAL_W-1:0] pal_i,
  input  ctrl_regs_t               ctrl_i,
  output logic [DW-1:0]            rd_data_o
);
  logic [DW-1:0] sel_val;
  logic [DW-1:0] idx_view;

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_PAL; i++) begin
      if (idx_i == IDX_W'(i)) sel_val = DW'(pal_i[i*PAL_W +: PAL_W]);
    end
    unique case (idx_i)
      IX_MODE:  sel_val = ctrl_i.mode;
      IX_OVSC:  sel_val = ctrl_i.ovsc;
      IX_PLANE: sel_val = DW'(ctrl_i.plane);
      IX_PAN:   sel_val = DW'(ctrl_i.pan);
      IX_PAGE:  sel_val = DW'(ctrl_i.page);
      default:  ;
    endcase
  end

  assign idx_view = {2'b00, video_en_i, idx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (rd_idx_i) rd_data_o <= idx_view;
    else if (rd_dat_i) rd_data_o <= sel_val;
  end
endmodule

// File: rtl/attr_port_regs.sv
module attr_port_regs
  import attr_port_pkg::*;
#(
  parameter int unsigned PAL_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [7:0]               wr_data_i,
  input  logic                     status_rd_i,
  input  logic                     rd_idx_i,
  input  logic                     rd_dat_i,
  output logic [7:0]               rd_data_o,
  output logic                     video_en_o,
  output logic [16*PAL_W-1:0]      pal_o,
  output logic [7:0]               mode_o,
  output logic [7:0]               overscan_o,
  output logic [3:0]               plane_en_o,
  output logic [3:0]               pan_o,
  output logic [3:0]               page_o
);
  logic             data_phase;
  logic             reg_we;
  logic [IDX_W-1:0] idx;
  ctrl_regs_t       ctrl;

  attr_phase i_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .status_rd_i  (status_rd_i),
    .data_phase_o (data_phase),
    .reg_we_o     (reg_we),
    .idx_o        (idx),
    .video_en_o   (video_en_o)
  );

  attr_regfile #(.PAL_W(PAL_W)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .idx_i   (idx),
    .wdata_i (wr_data_i),
    .pal_o   (pal_o),
    .ctrl_o  (ctrl)
  );

  attr_rdmux #(.PAL_W(PAL_W)) i_rdmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx_i),
    .rd_dat_i   (rd_dat_i),
    .idx_i      (idx),
    .video_en_i (video_en_o),
    .pal_i      (pal_o),
    .ctrl_i     (ctrl),
    .rd_data_o  (rd_data_o)
  );

  assign mode_o     = ctrl.mode;
  assign overscan_o = ctrl.ovsc;
  assign plane_en_o = ctrl.plane;
  assign pan_o      = ctrl.pan;
  assign page_o     = ctrl.page;
endmodule

// File: rtl/attr_port_regs_chk.sv
module attr_port_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       status_rd_i,
  input logic       rd_idx_i,
  input logic       rd_dat_i,
  input logic       data_phase,
  input logic [4:0] idx,
  input logic       video_en_o,
  input logic [7:0] rd_data_o,
  input logic [7:0] mode_o,
  input logic [7:0] overscan_o,
  input logic [3:0] plane_en_o,
  input logic [3:0] pan_o,
  input logic [3:0] page_o
);
  p_to_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !data_phase && !status_rd_i |=> data_phase);

  p_video_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !data_phase |=> video_en_o == $past(wr_data_i[5]));

  p_back_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && data_phase |=> !data_phase && $stable(idx) && $stable(video_en_o));

  p_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> !data_phase);

  p_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && data_phase && idx > 5'h14 |=>
      $stable(mode_o) && $stable(overscan_o) && $stable(plane_en_o) && $stable(pan_o) && $stable(page_o));

  p_idx_view_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i |=> rd_data_o[7:6] == 2'b00 && rd_data_o[5] == $past(video_en_o) && rd_data_o[4:0] == $past(idx));

  p_no_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dat_i || rd_idx_i) && !wr_en_i && !status_rd_i |=> $stable(data_phase));
endmodule

bind attr_port_regs attr_port_regs_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .status_rd_i (status_rd_i),
  .rd_idx_i    (rd_idx_i),
  .rd_dat_i    (rd_dat_i),
  .data_phase  (data_phase),
  .idx         (idx),
  .video_en_o  (video_en_o),
  .rd_data_o   (rd_data_o),
  .mode_o      (mode_o),
  .overscan_o  (overscan_o),
  .plane_en_o  (plane_en_o),
  .pan_o       (pan_o),
  .page_o      (page_o)
);

// File: tb/test_attr_port_regs.sv
module test_attr_port_regs;
  localparam int PAL_W = 6;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [7:0]       wr_data_i = '0;
  logic             status_rd_i = 1'b0;
  logic             rd_idx_i = 1'b0;
  logic             rd_dat_i = 1'b0;
  logic [7:0]       rd_data_o;
  logic             video_en_o;
  logic [16*PAL_W-1:0] pal_o;
  logic [7:0]       mode_o, overscan_o;
  logic [3:0]       plane_en_o, pan_o, page_o;

  always #5 clk_i = ~clk_i;

  attr_port_regs #(.PAL_W(PAL_W)) i_attr_port_regs (.*);

  int total = 0;
  int bad = 0;

  // model
  logic             ph_m = 0;
  logic [4:0]       idx_m = 0;
  logic             ven_m = 0;
  logic [PAL_W-1:0] pal_m [16];
  logic [7:0]       mode_m = 0, ovsc_m = 0;
  logic [3:0]       plane_m = 0, pan_m = 0, page_m = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sel_m();
    if (idx_m < 5'h10) return 8'(pal_m[idx_m[3:0]]);
    case (idx_m)
      5'h10: return mode_m;
      5'h11: return ovsc_m;
      5'h12: return 8'(plane_m);
      5'h13: return 8'(pan_m);
      5'h14: return 8'(page_m);
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_all(string tag);
    chk({tag, " video"}, 32'(video_en_o), 32'(ven_m));
    chk({tag, " mode"},  32'(mode_o), 32'(mode_m));
    chk({tag, " ovsc"},  32'(overscan_o), 32'(ovsc_m));
    chk({tag, " plane"}, 32'(plane_en_o), 32'(plane_m));
    chk({tag, " pan"},   32'(pan_o), 32'(pan_m));
    chk({tag, " page"},  32'(page_o), 32'(page_m));
    for (int i = 0; i < 16; i++)
      chk({tag, " pal"}, 32'(pal_o[i*PAL_W +: PAL_W]), 32'(pal_m[i]));
  endtask

  task automatic wr(logic [7:0] d, logic st, string tag);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d; status_rd_i = st;
    @(negedge clk_i);
    wr_en_i = 1'b0; status_rd_i = 1'b0;
    if (!ph_m) begin
      idx_m = d[4:0]; ven_m = d[5];
    end else begin
      if (idx_m < 5'h10) pal_m[idx_m[3:0]] = d[PAL_W-1:0];
      else case (idx_m)
        5'h10: mode_m = d;
        5'h11: ovsc_m = d;
        5'h12: plane_m = d[3:0];
        5'h13: pan_m = d[3:0];
        5'h14: page_m = d[3:0];
        default: ;
      endcase
    end
    ph_m = st ? 1'b0 : ~ph_m;
    check_all(tag);
  endtask

  task automatic status_rd();
    @(negedge clk_i); status_rd_i = 1'b1;
    @(negedge clk_i); status_rd_i = 1'b0;
    ph_m = 1'b0;
  endtask

  task automatic rd(bit index_view, string tag);
    @(negedge clk_i);
    if (index_view) begin
      rd_idx_i = 1'b1;
      exp_q.push_back({2'b00, ven_m, idx_m});
    end else begin
      rd_dat_i = 1'b1;
      exp_q.push_back(sel_m());
    end
    tag_q.push_back(tag);
    @(negedge clk_i);
    rd_idx_i = 1'b0; rd_dat_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk_i) begin
    if (rd_idx_i || rd_dat_i) begin
      #1;
      if (exp_q.size() == 0) chk("scoreboard empty", 0, 1);
      else chk(tag_q.pop_front(), 32'(rd_data_o), 32'(exp_q.pop_front()));
    end
  end

  bit done = 0;
  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) pal_m[i] = '0;
    repeat (3) @(negedge clk_i);
    check_all("R1 reset");
    chk("R1 rd_data reset", 32'(rd_data_o), 0);
    rst_ni = 1'b1;
    rd(1, "R1 index after reset");

    wr(8'h25, 0, "R2 index write");
    rd(1, "R2 index view");
    wr(8'h2A, 0, "R3 palette data");
    rd(1, "R3 index unchanged");
    rd(0, "R8 data read pal5");
    rd(0, "R8 data read again");
    wr(8'h11, 0, "R8 still index phase");
    rd(1, "R8 index 11 video off");
    wr(8'hFF, 0, "R5 overscan");
    rd(0, "R5 overscan read");

    wr(8'h32, 0, "R4 index plane");
    status_rd();
    wr(8'h13, 0, "R4 index after status");
    rd(1, "R4 index 13");
    wr(8'h07, 0, "R5 pan 7");
    wr(8'h32, 0, "R6 index plane");
    wr(8'h3F, 0, "R6 plane all");
    chk("R6 plane 0F", 32'(plane_en_o), 32'h0F);
    wr(8'h30, 0, "R5 index mode");
    wr(8'hA5, 0, "R9 mode");
    chk("R9 mode A5", 32'(mode_o), 32'hA5);
    wr(8'h34, 0, "R5 index page");
    wr(8'hFE, 0, "R5 page masked");
    rd(0, "R5 page read");

    wr(8'h37, 0, "R5 index unmapped");
    wr(8'h55, 0, "R5 unmapped ignored");
    rd(0, "R5 unmapped read zero");

    wr(8'hE3, 0, "R7 index top bits");
    rd(1, "R7 index view 23");
    wr(8'hFF, 0, "R5 palette mask");
    rd(0, "R5 palette masked read");

    for (int i = 0; i < 16; i++) begin
      wr(8'(i) | 8'h20, 0, "R5 pal index");
      wr(8'(i * 3 + 1), 0, "R9 pal data");
      rd(0, "R8 pal readback");
    end

    // write in index phase with status in same cycle
    wr(8'h24, 1, "R4 write+status");
    wr(8'h21, 0, "R4 next is index");
    rd(1, "R4 index 01");
    // write in data phase with status in same cycle
    wr(8'h12, 1, "R4 data+status");
    rd(0, "R4 pal1 written");
    wr(8'h10, 0, "R4 index after data+status");
    rd(1, "R4 index 10 video off");

    // both reads: index view wins
    @(negedge clk_i);
    rd_idx_i = 1'b1; rd_dat_i = 1'b1;
    exp_q.push_back({2'b00, ven_m, idx_m}); tag_q.push_back("R7 index priority");
    @(negedge clk_i);
    rd_idx_i = 1'b0; rd_dat_i = 1'b0;

    repeat (3) @(negedge clk_i);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule